// File: doc/BRIEF.md
# Virtual-Channel Frame and Error Interrupt Controller

This block collects the event pulses of a camera-stream receiver and turns them into one active-high interrupt line. It keeps a small frame-state machine for each of four virtual channels. The machine opens a frame on a frame-start pulse and closes it on a frame-end pulse. It flags a synchronisation error when the two are out of order. It flags a data error when a frame closes after a CRC error was reported on its channel while it was open. Packet-layer errors and physical-layer conditions set their own status bits directly.

Software reaches three registers through a flat register port: a control word holding the global interrupt enable, the interrupt status word, and an enable word that uses the same bit layout as the status word. Status bits are cleared by writing ones to them. The interrupt line is the global enable ANDed with the OR of every status bit that is also enabled. Double-bit ECC errors and SoT sync errors cannot be trusted to name the right channel, so they never reach the frame-state machines.

Top module: `frm_irq_ctrl`

## Requirements
- R1: After reset every status, enable and control bit reads 0, and `irq_o` is low.
- R2: Every frame-end pulse sets status bit 31, whether or not its channel had an open frame.
- R3: A frame-end pulse for channel n (0 to 3) when that channel has no open frame sets status bit 2n+1.
- R4: A frame-start pulse for channel n while that channel already has an open frame sets bit 2n+1 and starts a fresh frame. A CRC error seen before the restart is then forgotten.
- R5: A CRC error (`perr_kind_i`=1) tagged with channel n sets status bit 9 at once. If channel n has an open frame, the frame-end that closes it sets bit 2n.
- R6: Packet errors set status bits by kind: 0 unsupported data type sets bit 8, 2 corrected single-bit ECC sets bit 10, 3 double-bit ECC sets bit 11, 4 SoT sync sets bit 12, 5 SoT error sets bit 13. The `phy_evt_i` bits 0 to 4 set status bits 17 (stop state), 18 (line buffer full), 19 (short-packet FIFO not empty), 20 (short-packet FIFO full) and 21 (bad lane configuration).
- R7: Double-bit ECC and SoT sync errors, whatever their channel tag, neither open, close nor mark any channel's frame.
- R8: Writing the status word clears each bit written as 1 and leaves each bit written as 0.
- R9: When a hardware set and a software clear reach the same status bit in one cycle, the bit stays set.
- R10: `irq_o` is high exactly when the control bit 0 is 1 and some status bit is 1 whose enable bit is also 1.
- R11: Register addresses are: 0 control (bit 0 global enable), 1 status, 2 enable, and address 3 reads 0. Bits 14 to 16 and 22 to 30 of the status and enable words always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_pulse_i | input | 1 | Frame-start event, one cycle |
| fs_vc_i | input | 2 | Channel of the frame-start event |
| fe_pulse_i | input | 1 | Frame-end event, one cycle |
| fe_vc_i | input | 2 | Channel of the frame-end event |
| perr_pulse_i | input | 1 | Packet error event, one cycle |
| perr_kind_i | input | 3 | Packet error kind (see R5, R6) |
| perr_vc_i | input | 2 | Channel tag of the packet error |
| phy_evt_i | input | 5 | Physical-layer condition pulses (see R6) |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_o | output | 1 | Interrupt, active high |

## Verification
The hardest condition to reach is a frame-state machine whose memory of a CRC error must be dropped or must never be touched. One case is a CRC error followed by a restart of the frame. The other is an untrusted error tagged with the channel of an open frame. The stimulus opens a frame, sends the disputed event with a matching tag, and then closes the frame. The presence or absence of the data and synchronisation bits in the status word shows the hidden state at the ports. A second hard case is a hardware set and a software clear landing on the same edge. The bench drives a CRC pulse and a status write in the same cycle to produce it.

// File: rtl/frm_irq_pkg.sv
package frm_irq_pkg;

    localparam int STAT_W = 32;

    // packet error kinds carried on perr_kind_i
    typedef enum logic [2:0] {
        PE_UNSUP   = 3'd0,
        PE_CRC     = 3'd1,
        PE_ECC1    = 3'd2,
        PE_ECC2    = 3'd3,
        PE_SOTSYNC = 3'd4,
        PE_SOTERR  = 3'd5
    } perr_kind_e;

    // status bit positions other than the per-channel pairs
    localparam int B_UNSUP    = 8;
    localparam int B_CRC      = 9;
    localparam int B_ECC1     = 10;
    localparam int B_ECC2     = 11;
    localparam int B_SOTSYNC  = 12;
    localparam int B_SOTERR   = 13;
    localparam int B_PHY_LO   = 17;
    localparam int PHY_EVT_W  = 5;
    localparam int B_FRAME_END = 31;

    // register addresses
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_EN   = 2'd2;

    // per-channel result of one cycle of frame tracking
    typedef struct packed {
        logic sync_err;
        logic data_err;
    } trk_evt_t;

    // implemented status bits for a given channel count
    function automatic logic [STAT_W-1:0] impl_mask(input int nvc);
        logic [STAT_W-1:0] m;
        m = '0;
        for (int i = 0; i < 2 * nvc; i++) m[i] = 1'b1;
        for (int i = B_UNSUP; i <= B_SOTERR; i++) m[i] = 1'b1;
        for (int i = 0; i < PHY_EVT_W; i++) m[B_PHY_LO + i] = 1'b1;
        m[B_FRAME_END] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/frm_vc_tracker.sv
module frm_vc_tracker
    import frm_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fs_hit_i,
    input  logic     fe_hit_i,
    input  logic     crc_hit_i,
    output trk_evt_t evt_o
);

    logic in_frame_q, crc_seen_q;
    logic in_frame_d, crc_seen_d;

    // frame end is handled before a frame start in the same cycle
    always_comb begin
        logic open_after_fe;
        evt_o         = '0;
        in_frame_d    = in_frame_q;
        crc_seen_d    = crc_seen_q | (crc_hit_i & in_frame_q);
        open_after_fe = in_frame_q;
        if (fe_hit_i) begin
            evt_o.sync_err = ~in_frame_q;
            evt_o.data_err = in_frame_q & (crc_seen_q | crc_hit_i);
            open_after_fe  = 1'b0;
            in_frame_d     = 1'b0;
            crc_seen_d     = 1'b0;
        end
        if (fs_hit_i) begin
            evt_o.sync_err = evt_o.sync_err | open_after_fe;
            in_frame_d     = 1'b1;
            crc_seen_d     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            crc_seen_q <= 1'b0;
        end else begin
            in_frame_q <= in_frame_d;
            crc_seen_q <= crc_seen_d;
        end
    end

    // R4
    fs_opens_chk: assert property (@(posedge clk) disable iff (rst)
        fs_hit_i |=> in_frame_q);

    // R3
    fe_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (fe_hit_i && !fs_hit_i) |=> !in_frame_q);

    // R7
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!fs_hit_i && !fe_hit_i) |=> (in_frame_q == $past(in_frame_q)));

    // R5
    data_err_open_chk: assert property (@(posedge clk) disable iff (rst)
        evt_o.data_err |-> in_frame_q);

endmodule

// File: rtl/frm_err_decode.sv
module frm_err_decode
    import frm_irq_pkg::*;
#(
    parameter int NUM_VC = 4
) (
    input  trk_evt_t [NUM_VC-1:0]    trk_i,
    input  logic                     fe_pulse_i,
    input  logic                     perr_pulse_i,
    input  logic [2:0]               perr_kind_i,
    input  logic [PHY_EVT_W-1:0]     phy_evt_i,
    output logic [STAT_W-1:0]        set_o
);

    perr_kind_e kind;
    assign kind = perr_kind_e'(perr_kind_i);

    always_comb begin
        set_o = '0;
        for (int v = 0; v < NUM_VC; v++) begin
            set_o[2*v]   = trk_i[v].data_err;
            set_o[2*v+1] = trk_i[v].sync_err;
        end
        set_o[B_FRAME_END] = fe_pulse_i;
        if (perr_pulse_i) begin
            case (kind)
                PE_UNSUP:   set_o[B_UNSUP]   = 1'b1;
                PE_CRC:     set_o[B_CRC]     = 1'b1;
                PE_ECC1:    set_o[B_ECC1]    = 1'b1;
                PE_ECC2:    set_o[B_ECC2]    = 1'b1;
                PE_SOTSYNC: set_o[B_SOTSYNC] = 1'b1;
                PE_SOTERR:  set_o[B_SOTERR]  = 1'b1;
                default:    ;
            endcase
        end
        for (int i = 0; i < PHY_EVT_W; i++) set_o[B_PHY_LO + i] = phy_evt_i[i];
    end

endmodule

// File: rtl/frm_irq_regs.sv
module frm_irq_regs
    import frm_irq_pkg::*;
#(
    parameter int NUM_VC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] set_i,
    input  logic [1:0]        reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [STAT_W-1:0] reg_wdata_i,
    output logic [STAT_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    localparam logic [STAT_W-1:0] MASK = impl_mask(NUM_VC);

    logic [STAT_W-1:0] stat_q, en_q, clr;
    logic              gie_q;
    logic              wr_stat, wr_en, wr_ctrl;

    assign wr_stat = reg_wr_i && (reg_addr_i == A_STAT);
    assign wr_en   = reg_wr_i && (reg_addr_i == A_EN);
    assign wr_ctrl = reg_wr_i && (reg_addr_i == A_CTRL);
    assign clr     = wr_stat ? reg_wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            en_q   <= '0;
            gie_q  <= 1'b0;
        end else begin
            stat_q <= ((stat_q & ~clr) | set_i) & MASK;
            if (wr_en)   en_q  <= reg_wdata_i & MASK;
            if (wr_ctrl) gie_q <= reg_wdata_i[0];
        end
    end

    always_comb begin
        case (reg_addr_i)
            A_CTRL:  reg_rdata_o = {{(STAT_W-1){1'b0}}, gie_q};
            A_STAT:  reg_rdata_o = stat_q;
            A_EN:    reg_rdata_o = en_q;
            default: reg_rdata_o = '0;
        endcase
    end

    assign irq_o = gie_q & |(stat_q & en_q);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((stat_q & $past(set_i & MASK)) == $past(set_i & MASK)));

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stat |=> ((stat_q & $past(reg_wdata_i & ~set_i)) == '0));

    // R10
    gie_off_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !reg_wdata_i[0]) |=> !irq_o);

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((stat_q | en_q) & ~MASK) == '0);

endmodule

// File: rtl/frm_irq_ctrl.sv
module frm_irq_ctrl
    import frm_irq_pkg::*;
#(
    parameter int NUM_VC = 4,
    localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fs_pulse_i,
    input  logic [VC_W-1:0]   fs_vc_i,
    input  logic              fe_pulse_i,
    input  logic [VC_W-1:0]   fe_vc_i,
    input  logic              perr_pulse_i,
    input  logic [2:0]        perr_kind_i,
    input  logic [VC_W-1:0]   perr_vc_i,
    input  logic [4:0]        phy_evt_i,
    input  logic [1:0]        reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);

    trk_evt_t [NUM_VC-1:0] trk;
    logic [STAT_W-1:0]     set_vec;
    logic                  crc_evt;

    // only CRC errors reach the frame machines; untrusted tags never do
    assign crc_evt = perr_pulse_i && (perr_kind_e'(perr_kind_i) == PE_CRC);

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        frm_vc_tracker u_trk (
            .clk       (clk),
            .rst       (rst),
            .fs_hit_i  (fs_pulse_i && (fs_vc_i == VC_W'(v))),
            .fe_hit_i  (fe_pulse_i && (fe_vc_i == VC_W'(v))),
            .crc_hit_i (crc_evt && (perr_vc_i == VC_W'(v))),
            .evt_o     (trk[v])
        );
    end

    frm_err_decode #(.NUM_VC(NUM_VC)) u_dec (
        .trk_i        (trk),
        .fe_pulse_i   (fe_pulse_i),
        .perr_pulse_i (perr_pulse_i),
        .perr_kind_i  (perr_kind_i),
        .phy_evt_i    (phy_evt_i),
        .set_o        (set_vec)
    );

    frm_irq_regs #(.NUM_VC(NUM_VC)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .set_i       (set_vec),
        .reg_addr_i  (reg_addr_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    // R2
    frame_end_flag_chk: assert property (@(posedge clk) disable iff (rst)
        fe_pulse_i |-> set_vec[B_FRAME_END]);

endmodule

// File: tb/frm_irq_ctrl_bench.sv
module frm_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fs_pulse = 0, fe_pulse = 0, perr_pulse = 0, reg_wr = 0;
    logic [1:0]  fs_vc = 0, fe_vc = 0, perr_vc = 0, reg_addr = 1;
    logic [2:0]  perr_kind = 0;
    logic [4:0]  phy_evt = 0;
    logic [31:0] reg_wdata = 0, rdata;
    logic        irq;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    frm_irq_ctrl u_frm_irq_ctrl (
        .clk(clk), .rst(rst),
        .fs_pulse_i(fs_pulse), .fs_vc_i(fs_vc),
        .fe_pulse_i(fe_pulse), .fe_vc_i(fe_vc),
        .perr_pulse_i(perr_pulse), .perr_kind_i(perr_kind), .perr_vc_i(perr_vc),
        .phy_evt_i(phy_evt),
        .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic fs(input logic [1:0] v);
        @(negedge clk); fs_pulse = 1; fs_vc = v;
        @(negedge clk); fs_pulse = 0;
    endtask

    task automatic fe(input logic [1:0] v);
        @(negedge clk); fe_pulse = 1; fe_vc = v;
        @(negedge clk); fe_pulse = 0;
    endtask

    task automatic perr(input logic [2:0] k, input logic [1:0] v);
        @(negedge clk); perr_pulse = 1; perr_kind = k; perr_vc = v;
        @(negedge clk); perr_pulse = 0;
    endtask

    task automatic clear_all();
        logic [31:0] d;
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d);
        chk("R8 clear all", d, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); chk("R1 ctrl", d, 0);
        rd(2'd1, d); chk("R1 status", d, 0);
        rd(2'd2, d); chk("R1 enable", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_unmatched_end();
        logic [31:0] d;
        fe(2'd2);
        rd(2'd1, d);
        chk("R3 R2 unmatched end vc2", d, 32'h8000_0020);
        clear_all();
    endtask

    task automatic t_clean_frame();
        logic [31:0] d;
        fs(2'd0);
        rd(2'd1, d); chk("R2 start alone sets nothing", d, 0);
        fe(2'd0);
        rd(2'd1, d); chk("R2 clean frame vc0", d, 32'h8000_0000);
        clear_all();
    endtask

    task automatic t_crc_frame();
        logic [31:0] d;
        fs(2'd3);
        perr(3'd1, 2'd3);
        rd(2'd1, d); chk("R5 crc bit immediate", d, 32'h0000_0200);
        fe(2'd3);
        rd(2'd1, d); chk("R5 data error vc3", d, 32'h8000_0240);
        clear_all();
    endtask

    task automatic t_double_start();
        logic [31:0] d;
        fs(2'd1);
        perr(3'd1, 2'd1);
        fs(2'd1);
        rd(2'd1, d); chk("R4 restart sync vc1", d, 32'h0000_0208);
        fe(2'd1);
        rd(2'd1, d); chk("R4 restart drops crc", d, 32'h8000_0208);
        clear_all();
    endtask

    task automatic t_untrusted();
        logic [31:0] d;
        fs(2'd1);
        perr(3'd3, 2'd1);
        perr(3'd4, 2'd1);
        fe(2'd1);
        rd(2'd1, d); chk("R7 open frame untouched", d, 32'h8000_1800);
        clear_all();
        perr(3'd3, 2'd0);
        perr(3'd4, 2'd0);
        fe(2'd0);
        rd(2'd1, d); chk("R7 closed frame stays closed", d, 32'h8000_1802);
        clear_all();
    endtask

    task automatic t_other_bits();
        logic [31:0] d;
        perr(3'd0, 2'd0);
        perr(3'd2, 2'd2);
        perr(3'd5, 2'd3);
        rd(2'd1, d); chk("R6 packet kinds", d, 32'h0000_2500);
        @(negedge clk); phy_evt = 5'b10101;
        @(negedge clk); phy_evt = 5'b01010;
        @(negedge clk); phy_evt = 0;
        rd(2'd1, d); chk("R6 phy events", d, 32'h003E_2500);
        wr(2'd1, 32'h0000_0100);
        rd(2'd1, d); chk("R8 partial clear", d, 32'h003E_2400);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, d); chk("R11 enable mask", d, 32'h803E_3FFF);
        rd(2'd3, d); chk("R11 addr3 zero", d, 0);
        wr(2'd2, 0);
        clear_all();
    endtask

    task automatic t_irq();
        logic [31:0] d;
        perr(3'd2, 2'd0);
        rd(2'd1, d);
        chk("R10 no enable", {31'b0, irq}, 0);
        wr(2'd2, 32'h0000_0400);
        #1 chk("R10 gie off", {31'b0, irq}, 0);
        wr(2'd0, 32'h1);
        rd(2'd0, d); chk("R11 ctrl readback", d, 1);
        chk("R10 irq on", {31'b0, irq}, 1);
        wr(2'd2, 32'h0000_0200);
        #1 chk("R10 other bit enabled", {31'b0, irq}, 0);
        wr(2'd2, 32'h0000_0400);
        wr(2'd1, 32'h0000_0400);
        #1 chk("R10 cleared drops irq", {31'b0, irq}, 0);
        wr(2'd0, 0);
        wr(2'd2, 0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        perr(3'd0, 2'd0);
        @(negedge clk);
        perr_pulse = 1; perr_kind = 3'd1; perr_vc = 0;
        reg_addr = 2'd1; reg_wdata = 32'h0000_0300; reg_wr = 1;
        @(negedge clk);
        perr_pulse = 0; reg_wr = 0;
        rd(2'd1, d); chk("R9 set beats clear", d, 32'h0000_0200);
        clear_all();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        t_reset();
        t_unmatched_end();
        t_clean_frame();
        t_crc_frame();
        t_double_start();
        t_untrusted();
        t_other_bits();
        t_irq();
        t_set_wins();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule